// File: doc/BRIEF.md
# Video Test Pattern Generator

This block generates a synthetic interlaced video raster for bring-up and for checking a display or capture path without a live source. It runs from a single clock and steps one pixel on every second clock while its enable is high. Each step presents 8-bit luma and two 8-bit chroma values, active-low horizontal and vertical sync, an active-picture flag and a field flag. A one-cycle strobe marks each new pixel.

The default raster is 858 pixel periods per line and 525 lines per frame. The frame is split into two interlaced fields, and the active picture is 720 by 462. A white frame two pixels wide outlines the active picture. Inside it, horizontal bands hold a colour bar strip, a grey ramp, a horizontal multiburst whose solid half depends on the field, a vertical multiburst and a grid of vertical lines. A small white cursor moves across the line band once per frame. Every timing value and band boundary is a parameter, so a small raster can be built for quick checks.

Top module: `tpg_top`

## Requirements
- R1: While `en` is high, the block advances one pixel every second clock. `pixStb` is high for exactly one cycle per new pixel, and it is low on the alternate cycles. After `rst` is released, `pixStb` first rises on the second clock edge. That first pixel is line 0, position 0.
- R2: A line holds LINE_TOTAL pixel positions, numbered 0 up. A frame holds FRAME_LINES lines. Counting wraps from the last position of the last line back to position 0 of line 0.
- R3: Lines 0 to FRAME_LINES/2-1 form field 0, and `fieldOut` is 0 there. The remaining lines form field 1, and `fieldOut` is 1 there. Active row y is 2*(field line - V_ACT_START) + field, where the field line is counted from the start of its field.
- R4: `hsyncN` is 0 for line positions below HS_LEN and 1 otherwise. `vsyncN` is 0 on field lines VS_START to VS_START+VS_LEN-1 of each field and 1 otherwise.
- R5: `activeOut` is 1 only when the line position lies in [H_ACT_START, H_ACT_START+ACT_W) and the field line lies in [V_ACT_START, V_ACT_START+ACT_H/2). Active column x is the line position minus H_ACT_START. Outside the active area the outputs are luma 16 and chroma 128/128.
- R6: Active pixels with x<2, x>=ACT_W-2, y<2 or y>=ACT_H-2 are white: luma 235, chroma 128/128. The border takes priority over every other pattern.
- R7: Rows below BAR_END show eight bars, each ACT_W/8 wide, from left to right. As (luma, Cb, Cr) the bars are white (235,128,128), yellow (162,44,142), cyan (131,156,44), green (112,72,58), magenta (84,184,198), red (65,100,212), blue (35,212,114) and black (16,128,128).
- R8: Rows from BAR_END up to RAMP_END show a grey ramp. Its luma is floor(x*255/(ACT_W-1)) and its chroma is 128/128.
- R9: Rows from RAMP_END up to HMB_END show the horizontal multiburst. The left half is solid white (235) in field 0, and the right half is solid white in field 1. In the other half, with local column c and segment s = c/(ACT_W/8), luma is 235 when bit s of c is 1 and 16 when it is 0.
- R10: Rows from HMB_END up to VMB_END show the vertical multiburst. With segment s = x/(ACT_W/4), luma is 235 when bit s of the row y is 1 and 16 when it is 0. Chroma is 128/128.
- R11: Rows from VMB_END up to the bottom border show vertical lines. Luma is 235 where x is a multiple of LINE_PITCH and 16 elsewhere.
- R12: A white square of CUR_SIZE by CUR_SIZE, with top row CUR_Y, overrides the bands. Its left column is 2 in frame 0 and advances by CUR_STEP each frame. It returns to 2 when the next column would pass ACT_W-2-CUR_SIZE.
- R13: While `en` is low, no pixel advances, `pixStb` stays 0 and all outputs hold. Once `en` returns high, the raster resumes from the next position.
- R14: During `rst` the outputs hold: luma 16, chroma 128/128, `hsyncN`=1, `vsyncN`=1, `activeOut`=0, `fieldOut`=0, `pixStb`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the pixel rate is half of it |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes the raster |
| lumaOut | output | 8 | Luma of the current pixel |
| cbOut | output | 8 | Blue-difference chroma |
| crOut | output | 8 | Red-difference chroma |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| activeOut | output | 1 | High inside the active picture |
| fieldOut | output | 1 | Field flag: 0 first field, 1 second field |
| pixStb | output | 1 | One-cycle pulse for each new pixel |

## Verification
The raster runs from reset over seven frames of a reduced-size configuration. Fixed sample points then compare pixel values and flags against hand-computed results. Points in each band separate the colour lookup, the ramp arithmetic and the field-dependent multiburst halves. Sampling the same positions in field 0 and field 1 exposes any wrong field split or row interleave. The cursor is sampled in frames 0, 1, 5 and 6, which distinguishes a stuck cursor, a wrong step size and a wrong wrap point. A pause of the enable in the middle of a frame must hold every output, and the following samples must still match, which shows that the pause dropped no position.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int CW = 12;

  localparam logic [7:0] LVL_BLACK   = 8'd16;
  localparam logic [7:0] LVL_WHITE   = 8'd235;
  localparam logic [7:0] LVL_NEUTRAL = 8'd128;

  typedef struct packed {
    logic          advance;
    logic          active;
    logic          hsyncN;
    logic          vsyncN;
    logic          field;
    logic [CW-1:0] x;
    logic [CW-1:0] y;
    logic [CW-1:0] curX;
  } tpg_strobe_t;
endpackage

// File: rtl/tpg_bar_color.sv
module tpg_bar_color (
  input  logic [2:0] barIdx,
  output logic [7:0] barY,
  output logic [7:0] barU,
  output logic [7:0] barV
);
  always_comb begin
    unique case (barIdx)
      3'd0: {barY, barU, barV} = {8'd235, 8'd128, 8'd128};
      3'd1: {barY, barU, barV} = {8'd162, 8'd44,  8'd142};
      3'd2: {barY, barU, barV} = {8'd131, 8'd156, 8'd44};
      3'd3: {barY, barU, barV} = {8'd112, 8'd72,  8'd58};
      3'd4: {barY, barU, barV} = {8'd84,  8'd184, 8'd198};
      3'd5: {barY, barU, barV} = {8'd65,  8'd100, 8'd212};
      3'd6: {barY, barU, barV} = {8'd35,  8'd212, 8'd114};
      3'd7: {barY, barU, barV} = {8'd16,  8'd128, 8'd128};
    endcase
  end
endmodule

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
#(
  parameter int LINE_TOTAL  = 858,
  parameter int H_ACT_START = 122,
  parameter int HS_LEN      = 64,
  parameter int FRAME_LINES = 525,
  parameter int V_ACT_START = 20,
  parameter int VS_START    = 3,
  parameter int VS_LEN      = 3,
  parameter int ACT_W       = 720,
  parameter int ACT_H       = 462,
  parameter int BORDER      = 2,
  parameter int CUR_SIZE    = 16,
  parameter int CUR_STEP    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  output tpg_strobe_t strb
);
  localparam logic [CW-1:0] H_LAST    = CW'(LINE_TOTAL - 1);
  localparam logic [CW-1:0] V_LAST    = CW'(FRAME_LINES - 1);
  localparam logic [CW-1:0] F0_LINES  = CW'(FRAME_LINES / 2);
  localparam logic [CW-1:0] F_ROWS    = CW'(ACT_H / 2);
  localparam logic [CW-1:0] HA_LO     = CW'(H_ACT_START);
  localparam logic [CW-1:0] HA_HI     = CW'(H_ACT_START + ACT_W);
  localparam logic [CW-1:0] VA_LO     = CW'(V_ACT_START);
  localparam logic [CW-1:0] VS_LO     = CW'(VS_START);
  localparam logic [CW-1:0] VS_HI     = CW'(VS_START + VS_LEN);
  localparam logic [CW-1:0] HS_HI     = CW'(HS_LEN);
  localparam logic [CW-1:0] CUR_MIN   = CW'(BORDER);
  localparam logic [CW-1:0] CUR_MAX   = CW'(ACT_W - BORDER - CUR_SIZE);
  localparam logic [CW-1:0] CUR_INC   = CW'(CUR_STEP);

  logic          pixEn;
  logic [CW-1:0] hCnt, vCnt, curX;
  logic          advance, lastPix, lastLine;
  logic          field;
  logic [CW-1:0] fLine, curNext;

  assign advance  = pixEn & en;
  assign lastPix  = (hCnt == H_LAST);
  assign lastLine = (vCnt == V_LAST);
  assign curNext  = curX + CUR_INC;

  always_ff @(posedge clk) begin
    if (rst) begin
      pixEn <= 1'b0;
      hCnt  <= '0;
      vCnt  <= '0;
      curX  <= CUR_MIN;
    end else begin
      pixEn <= en & ~pixEn;
      if (advance) begin
        if (lastPix) begin
          hCnt <= '0;
          if (lastLine) begin
            vCnt <= '0;
            curX <= (curNext > CUR_MAX) ? CUR_MIN : curNext;
          end else begin
            vCnt <= vCnt + 1'b1;
          end
        end else begin
          hCnt <= hCnt + 1'b1;
        end
      end
    end
  end

  assign field = (vCnt >= F0_LINES);
  assign fLine = field ? (vCnt - F0_LINES) : vCnt;

  always_comb begin
    strb.advance = advance;
    strb.field   = field;
    strb.hsyncN  = ~(hCnt < HS_HI);
    strb.vsyncN  = ~((fLine >= VS_LO) && (fLine < VS_HI));
    strb.active  = (hCnt >= HA_LO) && (hCnt < HA_HI) &&
                   (fLine >= VA_LO) && (fLine < VA_LO + F_ROWS);
    strb.x       = hCnt - HA_LO;
    strb.y       = ((fLine - VA_LO) << 1) | CW'(field);
    strb.curX    = curX;
  end

  AST_PIXEN_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    pixEn |=> !pixEn); // R1
  AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (hCnt <= H_LAST) && (vCnt <= V_LAST)); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (advance && lastPix && lastLine) |=> (hCnt == '0 && vCnt == '0)); // R2
  AST_CURSOR_BOUND: assert property (@(posedge clk) disable iff (rst)
    (curX >= CUR_MIN) && (curX <= CUR_MAX)); // R12
  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(hCnt) && $stable(vCnt))); // R13
endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int ACT_W      = 720,
  parameter int ACT_H      = 462,
  parameter int BORDER     = 2,
  parameter int BAR_END    = 120,
  parameter int RAMP_END   = 200,
  parameter int HMB_END    = 280,
  parameter int VMB_END    = 360,
  parameter int LINE_PITCH = 16,
  parameter int CUR_SIZE   = 16,
  parameter int CUR_Y      = 400
) (
  input  logic        clk,
  input  logic        rst,
  input  tpg_strobe_t strb,
  output logic [7:0]  lumaOut,
  output logic [7:0]  cbOut,
  output logic [7:0]  crOut,
  output logic        hsyncN,
  output logic        vsyncN,
  output logic        activeOut,
  output logic        fieldOut,
  output logic        pixStb
);
  localparam logic [CW-1:0] BAR_W   = CW'(ACT_W / 8);
  localparam logic [CW-1:0] HALF_W  = CW'(ACT_W / 2);
  localparam logic [CW-1:0] HSEG_W  = CW'(ACT_W / 8);
  localparam logic [CW-1:0] VSEG_W  = CW'(ACT_W / 4);
  localparam logic [CW-1:0] B_LO    = CW'(BORDER);
  localparam logic [CW-1:0] B_XHI   = CW'(ACT_W - BORDER);
  localparam logic [CW-1:0] B_YHI   = CW'(ACT_H - BORDER);
  localparam logic [CW-1:0] Y_BAR   = CW'(BAR_END);
  localparam logic [CW-1:0] Y_RAMP  = CW'(RAMP_END);
  localparam logic [CW-1:0] Y_HMB   = CW'(HMB_END);
  localparam logic [CW-1:0] Y_VMB   = CW'(VMB_END);
  localparam logic [CW-1:0] PITCH   = CW'(LINE_PITCH);
  localparam logic [CW-1:0] C_SIZE  = CW'(CUR_SIZE);
  localparam logic [CW-1:0] C_TOP   = CW'(CUR_Y);
  localparam logic [CW+7:0] RAMP_DIV = (CW+8)'(ACT_W - 1);

  logic [CW-1:0] x, y, hLocal;
  logic          isBorder, inCur, rectB, hBit, vBit, linesOn;
  logic [1:0]    hSeg, vSeg;
  logic [2:0]    barIdx;
  logic [7:0]    barY, barU, barV, rampY;
  logic [CW+7:0] rampProd;
  logic [7:0]    nxtY, nxtU, nxtV;

  assign x = strb.x;
  assign y = strb.y;

  tpg_bar_color u_bar (
    .barIdx (barIdx),
    .barY   (barY),
    .barU   (barU),
    .barV   (barV)
  );

  always_comb begin
    isBorder = (x < B_LO) || (x >= B_XHI) || (y < B_LO) || (y >= B_YHI);
    inCur    = (x >= strb.curX) && (x < strb.curX + C_SIZE) &&
               (y >= C_TOP) && (y < C_TOP + C_SIZE);
    barIdx   = 3'(x / BAR_W);
    rampProd = {8'd0, x} * (CW+8)'(255);
    rampY    = 8'(rampProd / RAMP_DIV);
    rectB    = (x >= HALF_W);
    hLocal   = rectB ? (x - HALF_W) : x;
    hSeg     = 2'(hLocal / HSEG_W);
    hBit     = hLocal[hSeg];
    vSeg     = 2'(x / VSEG_W);
    vBit     = y[vSeg];
    linesOn  = ((x % PITCH) == '0);

    nxtU = LVL_NEUTRAL;
    nxtV = LVL_NEUTRAL;
    if (!strb.active) begin
      nxtY = LVL_BLACK;
    end else if (isBorder || inCur) begin
      nxtY = LVL_WHITE;
    end else if (y < Y_BAR) begin
      nxtY = barY;
      nxtU = barU;
      nxtV = barV;
    end else if (y < Y_RAMP) begin
      nxtY = rampY;
    end else if (y < Y_HMB) begin
      nxtY = ((rectB == strb.field) || hBit) ? LVL_WHITE : LVL_BLACK;
    end else if (y < Y_VMB) begin
      nxtY = vBit ? LVL_WHITE : LVL_BLACK;
    end else begin
      nxtY = linesOn ? LVL_WHITE : LVL_BLACK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lumaOut   <= LVL_BLACK;
      cbOut     <= LVL_NEUTRAL;
      crOut     <= LVL_NEUTRAL;
      hsyncN    <= 1'b1;
      vsyncN    <= 1'b1;
      activeOut <= 1'b0;
      fieldOut  <= 1'b0;
      pixStb    <= 1'b0;
    end else begin
      pixStb <= strb.advance;
      if (strb.advance) begin
        lumaOut   <= nxtY;
        cbOut     <= nxtU;
        crOut     <= nxtV;
        hsyncN    <= strb.hsyncN;
        vsyncN    <= strb.vsyncN;
        activeOut <= strb.active;
        fieldOut  <= strb.field;
      end
    end
  end

  AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !activeOut |-> (lumaOut == LVL_BLACK && cbOut == LVL_NEUTRAL &&
                    crOut == LVL_NEUTRAL)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strb.advance |=> ($stable(lumaOut) && $stable(activeOut) && !pixStb)); // R13
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pixStb |=> !pixStb); // R1
  AST_ACTIVE_SYNC_OFF: assert property (@(posedge clk) disable iff (rst)
    activeOut |-> (hsyncN && vsyncN)); // R4
endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int LINE_TOTAL  = 858,
  parameter int H_ACT_START = 122,
  parameter int HS_LEN      = 64,
  parameter int FRAME_LINES = 525,
  parameter int V_ACT_START = 20,
  parameter int VS_START    = 3,
  parameter int VS_LEN      = 3,
  parameter int ACT_W       = 720,
  parameter int ACT_H       = 462,
  parameter int BAR_END     = 120,
  parameter int RAMP_END    = 200,
  parameter int HMB_END     = 280,
  parameter int VMB_END     = 360,
  parameter int LINE_PITCH  = 16,
  parameter int CUR_SIZE    = 16,
  parameter int CUR_Y       = 400,
  parameter int CUR_STEP    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [7:0] lumaOut,
  output logic [7:0] cbOut,
  output logic [7:0] crOut,
  output logic       hsyncN,
  output logic       vsyncN,
  output logic       activeOut,
  output logic       fieldOut,
  output logic       pixStb
);
  localparam int BORDER = 2;

  tpg_strobe_t strb;

  tpg_ctrl #(
    .LINE_TOTAL (LINE_TOTAL), .H_ACT_START(H_ACT_START), .HS_LEN(HS_LEN),
    .FRAME_LINES(FRAME_LINES), .V_ACT_START(V_ACT_START),
    .VS_START(VS_START), .VS_LEN(VS_LEN), .ACT_W(ACT_W), .ACT_H(ACT_H),
    .BORDER(BORDER), .CUR_SIZE(CUR_SIZE), .CUR_STEP(CUR_STEP)
  ) u_ctrl (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .strb(strb)
  );

  tpg_datapath #(
    .ACT_W(ACT_W), .ACT_H(ACT_H), .BORDER(BORDER), .BAR_END(BAR_END),
    .RAMP_END(RAMP_END), .HMB_END(HMB_END), .VMB_END(VMB_END),
    .LINE_PITCH(LINE_PITCH), .CUR_SIZE(CUR_SIZE), .CUR_Y(CUR_Y)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .lumaOut  (lumaOut),
    .cbOut    (cbOut),
    .crOut    (crOut),
    .hsyncN   (hsyncN),
    .vsyncN   (vsyncN),
    .activeOut(activeOut),
    .fieldOut (fieldOut),
    .pixStb   (pixStb)
  );
endmodule

// File: tb/tpg_top_tb.sv
module tpg_top_tb;
  localparam int LT = 64;
  localparam int FL = 61;
  localparam int FRAME_PIX = LT * FL;
  localparam int END_PIX = 6 * FRAME_PIX + 24 * LT;

  typedef struct packed {
    logic [3:0] fr;
    logic [7:0] h;
    logic [7:0] vl;
    logic [7:0] ey;
    logic [7:0] eu;
    logic [7:0] ev;
    logic [3:0] flags;   // {active, hsyncN, vsyncN, field}
    logic [3:0] req;
  } probe_t;

  localparam int PN = 46;
  localparam probe_t PROBES [PN] = '{
    '{4'd0, 8'd0,  8'd0,  8'd16,  8'd128, 8'd128, 4'b0010, 4'd5},  // R5 blank
    '{4'd0, 8'd5,  8'd1,  8'd16,  8'd128, 8'd128, 4'b0000, 4'd4},  // R4 both syncs low
    '{4'd0, 8'd6,  8'd2,  8'd16,  8'd128, 8'd128, 4'b0100, 4'd4},  // R4 hsync ends
    '{4'd0, 8'd30, 8'd3,  8'd16,  8'd128, 8'd128, 4'b0110, 4'd4},  // R4 vsync ends
    '{4'd0, 8'd30, 8'd31, 8'd16,  8'd128, 8'd128, 4'b0101, 4'd3},  // R3 field 1 vsync
    '{4'd0, 8'd30, 8'd30, 8'd16,  8'd128, 8'd128, 4'b0111, 4'd3},  // R3 field 1 starts
    '{4'd0, 8'd12, 8'd4,  8'd235, 8'd128, 8'd128, 4'b1110, 4'd6},  // R6 corner
    '{4'd0, 8'd13, 8'd5,  8'd235, 8'd128, 8'd128, 4'b1110, 4'd6},  // R6 left edge
    '{4'd0, 8'd59, 8'd12, 8'd235, 8'd128, 8'd128, 4'b1110, 4'd6},  // R6 right edge
    '{4'd0, 8'd32, 8'd23, 8'd235, 8'd128, 8'd128, 4'b1110, 4'd6},  // R6 bottom f0
    '{4'd0, 8'd32, 8'd53, 8'd235, 8'd128, 8'd128, 4'b1111, 4'd6},  // R6 bottom f1
    '{4'd0, 8'd15, 8'd5,  8'd235, 8'd128, 8'd128, 4'b1110, 4'd7},  // R7 white
    '{4'd0, 8'd21, 8'd5,  8'd162, 8'd44,  8'd142, 4'b1110, 4'd7},  // R7 yellow
    '{4'd0, 8'd27, 8'd5,  8'd131, 8'd156, 8'd44,  4'b1110, 4'd7},  // R7 cyan
    '{4'd0, 8'd33, 8'd5,  8'd112, 8'd72,  8'd58,  4'b1110, 4'd7},  // R7 green
    '{4'd0, 8'd39, 8'd5,  8'd84,  8'd184, 8'd198, 4'b1110, 4'd7},  // R7 magenta
    '{4'd0, 8'd45, 8'd5,  8'd65,  8'd100, 8'd212, 4'b1110, 4'd7},  // R7 red
    '{4'd0, 8'd51, 8'd5,  8'd35,  8'd212, 8'd114, 4'b1110, 4'd7},  // R7 blue
    '{4'd0, 8'd57, 8'd5,  8'd16,  8'd128, 8'd128, 4'b1110, 4'd7},  // R7 black
    '{4'd0, 8'd14, 8'd9,  8'd10,  8'd128, 8'd128, 4'b1110, 4'd8},  // R8 ramp low
    '{4'd0, 8'd32, 8'd9,  8'd108, 8'd128, 8'd128, 4'b1110, 4'd8},  // R8 ramp mid
    '{4'd0, 8'd57, 8'd9,  8'd244, 8'd128, 8'd128, 4'b1110, 4'd8},  // R8 ramp high
    '{4'd0, 8'd16, 8'd12, 8'd235, 8'd128, 8'd128, 4'b1110, 4'd9},  // R9 left solid f0
    '{4'd0, 8'd44, 8'd12, 8'd16,  8'd128, 8'd128, 4'b1110, 4'd9},  // R9 right burst f0
    '{4'd0, 8'd42, 8'd12, 8'd235, 8'd128, 8'd128, 4'b1110, 4'd9},  // R9 right burst bit set
    '{4'd0, 8'd16, 8'd42, 8'd16,  8'd128, 8'd128, 4'b1111, 4'd9},  // R9 left burst f1
    '{4'd0, 8'd44, 8'd42, 8'd235, 8'd128, 8'd128, 4'b1111, 4'd9},  // R9 right solid f1
    '{4'd0, 8'd27, 8'd17, 8'd235, 8'd128, 8'd128, 4'b1110, 4'd10}, // R10 bit set
    '{4'd0, 8'd17, 8'd17, 8'd16,  8'd128, 8'd128, 4'b1110, 4'd10}, // R10 bit clear
    '{4'd0, 8'd52, 8'd16, 8'd235, 8'd128, 8'd128, 4'b1110, 4'd10}, // R10 segment 3
    '{4'd0, 8'd20, 8'd20, 8'd235, 8'd128, 8'd128, 4'b1110, 4'd11}, // R11 on pitch
    '{4'd0, 8'd21, 8'd20, 8'd16,  8'd128, 8'd128, 4'b1110, 4'd11}, // R11 off pitch
    '{4'd0, 8'd15, 8'd21, 8'd235, 8'd128, 8'd128, 4'b1110, 4'd12}, // R12 frame 0 cursor
    '{4'd0, 8'd18, 8'd21, 8'd16,  8'd128, 8'd128, 4'b1110, 4'd12}, // R12 beside cursor
    '{4'd1, 8'd23, 8'd21, 8'd235, 8'd128, 8'd128, 4'b1110, 4'd12}, // R12 frame 1 cursor
    '{4'd1, 8'd15, 8'd21, 8'd16,  8'd128, 8'd128, 4'b1110, 4'd12}, // R12 old spot cleared
    '{4'd5, 8'd55, 8'd21, 8'd235, 8'd128, 8'd128, 4'b1110, 4'd12}, // R12 last step
    '{4'd5, 8'd15, 8'd21, 8'd16,  8'd128, 8'd128, 4'b1110, 4'd12}, // R12 frame 5 left
    '{4'd6, 8'd15, 8'd21, 8'd235, 8'd128, 8'd128, 4'b1110, 4'd12}, // R12 wrapped
    '{4'd0, 8'd32, 8'd24, 8'd16,  8'd128, 8'd128, 4'b0110, 4'd5},  // R5 below active
    '{4'd0, 8'd60, 8'd12, 8'd16,  8'd128, 8'd128, 4'b0110, 4'd5},  // R5 right of active
    '{4'd0, 8'd11, 8'd12, 8'd16,  8'd128, 8'd128, 4'b0110, 4'd5},  // R5 left of active
    '{4'd1, 8'd32, 8'd9,  8'd108, 8'd128, 8'd128, 4'b1110, 4'd13}, // R13 after pause
    '{4'd1, 8'd0,  8'd0,  8'd16,  8'd128, 8'd128, 4'b0010, 4'd2},  // R2 frame wrap
    '{4'd0, 8'd63, 8'd60, 8'd16,  8'd128, 8'd128, 4'b0111, 4'd2},  // R2 last position
    '{4'd2, 8'd16, 8'd42, 8'd16,  8'd128, 8'd128, 4'b1111, 4'd3}   // R3 later frame
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b1;
  logic [7:0] lumaOut, cbOut, crOut;
  logic       hsyncN, vsyncN, activeOut, fieldOut, pixStb;

  int  total = 0;
  int  bad   = 0;
  int  p     = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  tpg_top #(
    .LINE_TOTAL(LT), .H_ACT_START(12), .HS_LEN(6), .FRAME_LINES(FL),
    .V_ACT_START(4), .VS_START(1), .VS_LEN(2), .ACT_W(48), .ACT_H(40),
    .BAR_END(10), .RAMP_END(16), .HMB_END(24), .VMB_END(32),
    .LINE_PITCH(8), .CUR_SIZE(4), .CUR_Y(33), .CUR_STEP(8)
  ) u_dut (
    .clk(clk), .rst(rst), .en(en), .lumaOut(lumaOut), .cbOut(cbOut),
    .crOut(crOut), .hsyncN(hsyncN), .vsyncN(vsyncN), .activeOut(activeOut),
    .fieldOut(fieldOut), .pixStb(pixStb)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // stream monitor: walks the probe table for every new pixel
  always @(negedge clk) begin
    if (!rst && pixStb && !done) begin
      for (int i = 0; i < PN; i++) begin
        if (int'(PROBES[i].fr) == p / FRAME_PIX && int'(PROBES[i].h) == p % LT &&
            int'(PROBES[i].vl) == (p / LT) % FL) begin
          chk({lumaOut, cbOut, crOut} ==
                {PROBES[i].ey, PROBES[i].eu, PROBES[i].ev},
              $sformatf("R%0d", PROBES[i].req),
              $sformatf("pixel f%0d h%0d v%0d yuv", PROBES[i].fr, PROBES[i].h, PROBES[i].vl),
              int'({lumaOut, cbOut, crOut}),
              int'({PROBES[i].ey, PROBES[i].eu, PROBES[i].ev}));
          chk({activeOut, hsyncN, vsyncN, fieldOut} == PROBES[i].flags,
              $sformatf("R%0d", PROBES[i].req),
              $sformatf("flags f%0d h%0d v%0d", PROBES[i].fr, PROBES[i].h, PROBES[i].vl),
              int'({activeOut, hsyncN, vsyncN, fieldOut}), int'(PROBES[i].flags));
        end
      end
      p++;
    end
  end

  initial begin
    logic [28:0] held;
    // R14: reset state
    repeat (3) @(negedge clk);
    chk(lumaOut == 8'd16, "R14", "reset luma", lumaOut, 16);
    chk(cbOut == 8'd128 && crOut == 8'd128, "R14", "reset chroma",
        int'({cbOut, crOut}), int'({8'd128, 8'd128}));
    chk({hsyncN, vsyncN, activeOut, fieldOut, pixStb} == 5'b11000, "R14",
        "reset flags", int'({hsyncN, vsyncN, activeOut, fieldOut, pixStb}), 24);
    rst = 1'b0;
    // R1: strobe on every second clock, first on the second edge
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk(pixStb == (k % 2 == 0), "R1", $sformatf("strobe cycle %0d", k),
          int'(pixStb), int'(k % 2 == 0));
    end
    // R13: pause in frame 1, outputs must hold
    wait (p >= FRAME_PIX + 100);
    @(negedge clk);
    en = 1'b0;
    held = {lumaOut, cbOut, crOut, hsyncN, vsyncN, activeOut, fieldOut, 1'b0};
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(!pixStb, "R13", "strobe while paused", int'(pixStb), 0);
      chk({lumaOut, cbOut, crOut, hsyncN, vsyncN, activeOut, fieldOut, 1'b0} == held,
          "R13", "outputs hold while paused",
          int'({lumaOut, cbOut, crOut}), int'(held[28:5]));
    end
    en = 1'b1;
    wait (p >= END_PIX);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d pixels", p, END_PIX);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule